// File: doc/BRIEF.md
# Byte-Port Packet Buffer Network Interface

This peripheral sits on a byte-addressed register bus and moves whole network frames between software and two streaming ports. It holds one receive frame and one transmit frame, each up to `FRAME_MAX` bytes (1514 by default). Software touches frame data one byte per bus access, through a receive data port and a transmit data port. A three-bit interrupt-control register drives one level-sensitive interrupt line.

On the receive side, a framed byte stream with start and end markers fills the receive buffer. The receive machine has two states. In IDLE it waits for a start beat. It goes from IDLE to FILL on a start beat that is not also an end beat, and from FILL back to IDLE on an end beat. A start beat that is also an end beat commits a one-byte frame and stays in IDLE. Each commit loads the receive count with the frame length, rewinds the read pointer and raises the receive-done flag.

On the transmit side, software first writes an expected length and then writes that many bytes. The transmit machine has two states. It goes from LOAD to SEND when the byte that brings the write pointer up to the length is written. It goes from SEND back to LOAD when the stream sink accepts the last byte, and at that moment the transmit-done flag is raised.

Top module: `pktnic_top`

## Requirements
- R1: Reading offset 0x00 returns the first four identification characters, with the first character in bits 7:0. Offset 0x04 returns the next four characters the same way. Offset 0x18 returns the parameter `IRQ_INFO`. Reading 0x20, or any address that is not one of the offsets below, returns zero.
- R2: A write to the transmit length register (0x10) stores the value if it is at most `FRAME_MAX` and stores 0 otherwise, comparing all 32 bits. The write also rewinds the transmit write pointer. Reading 0x10 returns the stored length.
- R3: While in LOAD with a nonzero length, each write to 0x20 stores `wdata[7:0]` at the write pointer and advances the pointer. When the pointer reaches the length, the frame leaves on the stream in write order, with `tx_last` on its final byte, and the stored length reads 0. Data-port writes are ignored while the length is 0 and while in SEND. `tx_valid`, `tx_data` and `tx_last` hold steady while `tx_ready` is low.
- R4: Interrupt-control bit 0 (transmit done) is set in the cycle after the stream accepts the final byte of a frame.
- R5: A frame that starts with a start beat and ends with an end beat is committed. The receive count (0x0C) becomes its length, capped at `FRAME_MAX`; bytes beyond the cap are dropped. Interrupt-control bit 1 (receive done) is set. A beat without a start marker in IDLE is dropped.
- R6: In IDLE, `rx_ready` is low while the receive count equals `FRAME_MAX`, and high otherwise.
- R7: While the receive count is nonzero, each read of 0x1C returns the next byte in arrival order and decrements the count. While the count is zero, reading 0x1C returns 0 and changes nothing.
- R8: A write to interrupt control (0x14) is decoded by priority. If bit 0 is set, only transmit-done is cleared. Otherwise, if bit 1 is set, only receive-done is cleared. Otherwise, if bit 31 is set, the test flag (bit 31) is set.
- R9: Reading 0x14 returns {test, 29'b0, receive-done, transmit-done} and clears the test flag afterwards.
- R10: `irq` is high whenever any interrupt-control bit is set. The busy register (0x08, bit 0) takes the value "any bit set" on each interrupt-control write and otherwise holds.
- R11: Writes to 0x00, 0x04, 0x08, 0x0C, 0x18 and 0x1C change nothing.
- R12: After reset, all counts, pointers, busy and interrupt bits are zero, `irq` and `tx_valid` are low, and `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe; wins if raised with `bus_rd` |
| bus_rd | input | 1 | Read strobe; side effects occur at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| rx_valid | input | 1 | Receive beat valid |
| rx_sop | input | 1 | Receive beat is the first of a frame |
| rx_eop | input | 1 | Receive beat is the last of a frame |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive beat accepted when high |
| tx_valid | output | 1 | Transmit byte valid |
| tx_last | output | 1 | Transmit byte is the last of the frame |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Stream sink accepts the byte |
| irq | output | 1 | Level interrupt |

## Verification
The checker assumes that at most one register operation takes effect per cycle. When both strobes are high the write wins, so the acknowledge and read-clear properties are conditioned on the absence of a done event in the same cycle. The stimulus never raises both strobes together, and it drives receive beats only as properly framed sequences or as one deliberate stray beat. The hold property on the transmit stream assumes only that `tx_ready` may drop at any cycle. The stimulus covers this by running some frames with a ready pattern that stalls one cycle in four.

// File: rtl/nic_pkg.sv
package nic_pkg;

    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_ID_LO  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_ID_HI  = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_BUSY   = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_RXLEN  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_TXLEN  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_ICTL   = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_IINFO  = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_RXPORT = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_TXPORT = 6'h20;

    localparam int ICTL_TXB   = 0;
    localparam int ICTL_RXB   = 1;
    localparam int ICTL_TESTB = 31;

    typedef enum logic [0:0] {
        RX_IDLE = 1'b0,
        RX_FILL = 1'b1
    } rx_state_e;

    typedef enum logic [0:0] {
        TX_LOAD = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic test;
        logic rx_done;
        logic tx_done;
    } ictl_t;

    // Bus-order word of an 8-character tag: first character lands in bits 7:0.
    function automatic logic [31:0] id_word(input logic [63:0] tag, input logic upper);
        logic [31:0] src;
        src = upper ? tag[31:0] : tag[63:32];
        return {src[7:0], src[15:8], src[23:16], src[31:24]};
    endfunction

endpackage

// File: rtl/nic_rx_buf.sv
module nic_rx_buf
    import nic_pkg::*;
#(
    parameter int FRAME_MAX = 1514,
    parameter int CW        = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_valid,
    input  logic          s_sop,
    input  logic          s_eop,
    input  logic [7:0]    s_data,
    output logic          s_ready,
    input  logic          pop,
    output logic [7:0]    pop_byte,
    output logic [CW-1:0] count,
    output logic          done_evt,
    output logic          idle
);

    localparam logic [CW-1:0] LIMIT = CW'(FRAME_MAX);

    rx_state_e     st_q, st_d;
    logic [7:0]    mem [FRAME_MAX];
    logic [CW-1:0] fill_q, fill_d;
    logic [CW-1:0] cnt_q, rdp_q;
    logic [CW-1:0] widx;
    logic          store, commit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_IDLE;
        else        st_q <= st_d;
    end

    // next state and outputs
    always_comb begin
        st_d    = st_q;
        s_ready = 1'b1;
        store   = 1'b0;
        widx    = fill_q;
        unique case (st_q)
            RX_IDLE: begin
                s_ready = (cnt_q < LIMIT);
                widx    = '0;
                store   = s_valid && s_ready && s_sop;
                if (store && !s_eop) st_d = RX_FILL;
            end
            RX_FILL: begin
                store = s_valid;
                if (s_valid && s_eop) st_d = RX_IDLE;
            end
            default: st_d = RX_IDLE;
        endcase
        commit = store && s_eop;
        fill_d = (widx < LIMIT) ? widx + 1'b1 : widx;
    end

    always_ff @(posedge clk) begin
        if (store && (widx < LIMIT)) mem[widx] <= s_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (store) begin
            fill_q <= fill_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rdp_q <= '0;
        end else if (commit) begin
            cnt_q <= fill_d;
            rdp_q <= '0;
        end else if (pop && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
            rdp_q <= rdp_q + 1'b1;
        end
    end

    assign pop_byte = (cnt_q != '0) ? mem[rdp_q] : 8'h00;
    assign count    = cnt_q;
    assign done_evt = commit;
    assign idle     = (st_q == RX_IDLE);

endmodule

// File: rtl/nic_tx_buf.sv
module nic_tx_buf
    import nic_pkg::*;
#(
    parameter int FRAME_MAX = 1514,
    parameter int CW        = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          len_wr,
    input  logic [31:0]   len_val,
    input  logic          dat_wr,
    input  logic [7:0]    dat_byte,
    output logic          m_valid,
    output logic          m_last,
    output logic [7:0]    m_data,
    input  logic          m_ready,
    output logic [CW-1:0] count,
    output logic          done_evt
);

    tx_state_e     st_q, st_d;
    logic [7:0]    mem [FRAME_MAX];
    logic [CW-1:0] cnt_q, wp_q, len_q, sp_q;
    logic          load_en, trigger, len_ok, xfer;

    assign len_ok  = (len_val <= 32'(FRAME_MAX));
    assign load_en = (st_q == TX_LOAD) && dat_wr && (cnt_q != '0);
    assign trigger = load_en && ((wp_q + 1'b1) == cnt_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_LOAD;
        else        st_q <= st_d;
    end

    // next state and outputs
    always_comb begin
        st_d    = st_q;
        m_valid = 1'b0;
        m_last  = 1'b0;
        unique case (st_q)
            TX_LOAD: begin
                if (trigger) st_d = TX_SEND;
            end
            TX_SEND: begin
                m_valid = 1'b1;
                m_last  = (sp_q == (len_q - 1'b1));
                if (m_ready && m_last) st_d = TX_LOAD;
            end
            default: st_d = TX_LOAD;
        endcase
        xfer     = m_valid && m_ready;
        done_evt = xfer && m_last;
    end

    assign m_data = mem[sp_q];

    always_ff @(posedge clk) begin
        if (load_en) mem[wp_q] <= dat_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            wp_q  <= '0;
            len_q <= '0;
        end else if (len_wr) begin
            cnt_q <= len_ok ? len_val[CW-1:0] : '0;
            wp_q  <= '0;
        end else if (trigger) begin
            len_q <= cnt_q;
            cnt_q <= '0;
            wp_q  <= '0;
        end else if (load_en) begin
            wp_q  <= wp_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (trigger) begin
            sp_q <= '0;
        end else if (xfer && !m_last) begin
            sp_q <= sp_q + 1'b1;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/nic_irq_ctl.sv
module nic_irq_ctl
    import nic_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  logic  ack_tx,
    input  logic  ack_rx,
    input  logic  req_test,
    input  logic  rd_en,
    input  logic  tx_set,
    input  logic  rx_set,
    output ictl_t bits,
    output logic  busy,
    output logic  irq
);

    ictl_t bits_q, bits_d;
    logic  busy_q;

    always_comb begin
        bits_d = bits_q;
        if (wr_en) begin
            if (ack_tx)        bits_d.tx_done = 1'b0;
            else if (ack_rx)   bits_d.rx_done = 1'b0;
            else if (req_test) bits_d.test    = 1'b1;
        end
        if (rd_en)  bits_d.test    = 1'b0;
        if (tx_set) bits_d.tx_done = 1'b1;
        if (rx_set) bits_d.rx_done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
            busy_q <= 1'b0;
        end else begin
            bits_q <= bits_d;
            if (wr_en) busy_q <= |bits_d;
        end
    end

    assign bits = bits_q;
    assign busy = busy_q;
    assign irq  = |bits_q;

endmodule

// File: rtl/pktnic_top.sv
module pktnic_top
    import nic_pkg::*;
#(
    parameter int          FRAME_MAX = 1514,
    parameter logic [63:0] ID_TEXT   = 64'h4255_464E_4943_3031,
    parameter logic [31:0] IRQ_INFO  = 32'd3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        rx_valid,
    input  logic        rx_sop,
    input  logic        rx_eop,
    input  logic [7:0]  rx_data,
    output logic        rx_ready,
    output logic        tx_valid,
    output logic        tx_last,
    output logic [7:0]  tx_data,
    input  logic        tx_ready,
    output logic        irq
);

    localparam int          CW     = $clog2(FRAME_MAX + 1);
    localparam logic [31:0] ID_LO  = id_word(ID_TEXT, 1'b0);
    localparam logic [31:0] ID_HI  = id_word(ID_TEXT, 1'b1);

    logic          wr_op, rd_op;
    logic [CW-1:0] rx_count, tx_count;
    logic [7:0]    rx_byte;
    logic          rx_evt, tx_evt, rx_idle;
    ictl_t         ictl;
    logic [2:0]    ictl_vec;
    logic          busy;

    assign wr_op    = bus_wr;
    assign rd_op    = bus_rd && !bus_wr;
    assign ictl_vec = ictl;

    nic_rx_buf #(.FRAME_MAX(FRAME_MAX), .CW(CW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_valid  (rx_valid),
        .s_sop    (rx_sop),
        .s_eop    (rx_eop),
        .s_data   (rx_data),
        .s_ready  (rx_ready),
        .pop      (rd_op && (bus_addr == OFS_RXPORT)),
        .pop_byte (rx_byte),
        .count    (rx_count),
        .done_evt (rx_evt),
        .idle     (rx_idle)
    );

    nic_tx_buf #(.FRAME_MAX(FRAME_MAX), .CW(CW)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .len_wr   (wr_op && (bus_addr == OFS_TXLEN)),
        .len_val  (bus_wdata),
        .dat_wr   (wr_op && (bus_addr == OFS_TXPORT)),
        .dat_byte (bus_wdata[7:0]),
        .m_valid  (tx_valid),
        .m_last   (tx_last),
        .m_data   (tx_data),
        .m_ready  (tx_ready),
        .count    (tx_count),
        .done_evt (tx_evt)
    );

    nic_irq_ctl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_op && (bus_addr == OFS_ICTL)),
        .ack_tx   (bus_wdata[ICTL_TXB]),
        .ack_rx   (bus_wdata[ICTL_RXB]),
        .req_test (bus_wdata[ICTL_TESTB]),
        .rd_en    (rd_op && (bus_addr == OFS_ICTL)),
        .tx_set   (tx_evt),
        .rx_set   (rx_evt),
        .bits     (ictl),
        .busy     (busy),
        .irq      (irq)
    );

    // read data mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_ID_LO:  bus_rdata = ID_LO;
            OFS_ID_HI:  bus_rdata = ID_HI;
            OFS_BUSY:   bus_rdata = {31'b0, busy};
            OFS_RXLEN:  bus_rdata = {{(32-CW){1'b0}}, rx_count};
            OFS_TXLEN:  bus_rdata = {{(32-CW){1'b0}}, tx_count};
            OFS_ICTL:   bus_rdata = {ictl.test, 29'b0, ictl.rx_done, ictl.tx_done};
            OFS_IINFO:  bus_rdata = IRQ_INFO;
            OFS_RXPORT: bus_rdata = {24'b0, rx_byte};
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/nic_chk.sv
module nic_chk
    import nic_pkg::*;
#(
    parameter int FRAME_MAX = 1514,
    parameter int CW        = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic [5:0]    bus_addr,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [1:0]    wd_lo,
    input logic          rx_ready,
    input logic          rx_idle,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_data,
    input logic          tx_last,
    input logic [2:0]    ictl_vec,
    input logic          tx_evt,
    input logic          rx_evt
);

    AST_TXLEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= CW'(FRAME_MAX)); // R2

    AST_RXLEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(FRAME_MAX)); // R5

    AST_RX_REFUSE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_idle && rx_count == CW'(FRAME_MAX)) |-> !rx_ready); // R6

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R3

    AST_TXDONE_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> ictl_vec[0]); // R4

    AST_RXDONE_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt |=> ictl_vec[1]); // R5

    AST_ACK_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_ICTL && wd_lo[0] && !tx_evt) |=> !ictl_vec[0]); // R8

    AST_ACK_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_ICTL && !wd_lo[0] && wd_lo[1] && !rx_evt) |=> !ictl_vec[1]); // R8

    AST_TEST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == OFS_ICTL) |=> !ictl_vec[2]); // R9

endmodule

bind pktnic_top nic_chk #(.FRAME_MAX(FRAME_MAX), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .wd_lo    (bus_wdata[1:0]),
    .rx_ready (rx_ready),
    .rx_idle  (rx_idle),
    .rx_count (rx_count),
    .tx_count (tx_count),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .ictl_vec (ictl_vec),
    .tx_evt   (tx_evt),
    .rx_evt   (rx_evt)
);

// File: tb/tb_pktnic_top.sv
`timescale 1ns/1ps
module tb_pktnic_top;

    localparam int FMAX = 1514;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        tx_ready;
    logic        irq;

    logic        bp_en = 1'b0;
    logic [2:0]  bp_cnt = '0;
    int          total = 0;
    int          bad = 0;
    int          frames = 0;
    int          cap_n = 0;
    int          last_len = 0;
    logic [7:0]  cap [0:2047];

    always #5 clk = ~clk;
    always @(posedge clk) bp_cnt <= bp_cnt + 3'd1;
    assign tx_ready = bp_en ? (bp_cnt[1:0] != 2'd0) : 1'b1;

    pktnic_top dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_sop(rx_sop),
        .rx_eop(rx_eop), .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
        .tx_last(tx_last), .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
    );

    // stream monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (tx_valid && tx_ready) begin
            cap[cap_n] = tx_data;
            if (tx_last) begin
                last_len = cap_n + 1;
                cap_n    = 0;
                frames   = frames + 1;
            end else begin
                cap_n = cap_n + 1;
            end
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run hung, act=running exp=finished");
        summary();
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1 bus_rd = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed + i * 7) & 255);
    endfunction

    task automatic send_rx(input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sop = (i == 0); rx_eop = (i == len - 1);
            rx_data = pat(seed, i);
            #1;
            while (!rx_ready) begin @(negedge clk); #1; end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
    endtask

    task automatic wait_frame(input int old);
        while (frames == old) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic send_tx(input int len, input int seed);
        int old;
        old = frames;
        wr(6'h10, 32'(len));
        for (int i = 0; i < len; i++) wr(6'h20, {24'h0, pat(seed, i)});
        wait_frame(old);
    endtask

    logic [31:0] v;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R12 reset state
        check("R12 irq", {31'b0, irq}, 0);
        check("R12 rx_ready", {31'b0, rx_ready}, 1);
        check("R12 tx_valid", {31'b0, tx_valid}, 0);
        rd(6'h08, v); check("R12 busy", v, 0);
        rd(6'h0C, v); check("R12 rx count", v, 0);
        rd(6'h10, v); check("R12 tx count", v, 0);
        rd(6'h14, v); check("R12 ictl", v, 0);

        // R1 identification and fixed reads
        rd(6'h00, v); check("R1 id low", v, 32'h4E46_5542);
        rd(6'h04, v); check("R1 id high", v, 32'h3130_4349);
        rd(6'h18, v); check("R1 irq info", v, 32'd3);
        rd(6'h20, v); check("R1 tx port read", v, 0);
        rd(6'h24, v); check("R1 outside window", v, 0);
        rd(6'h01, v); check("R1 unaligned", v, 0);

        // R11 writes to read-only offsets
        wr(6'h00, 32'hFFFF_FFFF); wr(6'h04, 32'hFFFF_FFFF); wr(6'h08, 32'hFFFF_FFFF);
        wr(6'h0C, 32'hFFFF_FFFF); wr(6'h18, 32'hFFFF_FFFF); wr(6'h1C, 32'hFFFF_FFFF);
        rd(6'h00, v); check("R11 id low kept", v, 32'h4E46_5542);
        rd(6'h08, v); check("R11 busy kept", v, 0);
        rd(6'h0C, v); check("R11 rx count kept", v, 0);
        rd(6'h18, v); check("R11 info kept", v, 32'd3);
        check("R11 irq low", {31'b0, irq}, 0);

        // R2 length sweep
        begin
            logic [31:0] lv [8];
            lv = '{32'd0, 32'd1, 32'd5, 32'd1513, 32'd1514, 32'd1515, 32'hFFFF_FFFF, 32'h0001_0005};
            foreach (lv[k]) begin
                wr(6'h10, lv[k]);
                rd(6'h10, v);
                check("R2 tx length store", v, (lv[k] <= FMAX) ? lv[k] : 32'd0);
            end
        end

        // R3 ignored data write with zero length, then a 2-byte frame
        wr(6'h10, 0);
        wr(6'h20, 32'hAA);
        rd(6'h10, v); check("R3 zero length write ignored", v, 0);
        begin
            int old;
            old = frames;
            wr(6'h10, 2); wr(6'h20, 32'h11); wr(6'h20, 32'h22);
            wait_frame(old);
            check("R3 len after zero-length write", last_len, 2);
            check("R3 byte0", {24'h0, cap[0]}, 32'h11);
            check("R3 byte1", {24'h0, cap[1]}, 32'h22);
        end
        wr(6'h14, 32'h1);

        // R2 length rewrite rewinds the pointer
        begin
            int old;
            old = frames;
            wr(6'h10, 3); wr(6'h20, 32'h99);
            wr(6'h10, 2); wr(6'h20, 32'h31); wr(6'h20, 32'h32);
            wait_frame(old);
            check("R2 rewind len", last_len, 2);
            check("R2 rewind byte0", {24'h0, cap[0]}, 32'h31);
        end
        wr(6'h14, 32'h1);

        // R3 R4 frame sweep, with and without backpressure
        begin
            int lens [6];
            lens = '{1, 2, 3, 7, 16, FMAX};
            foreach (lens[k]) begin
                int errs;
                bp_en = (k % 2 == 1);
                send_tx(lens[k], k * 13);
                check("R3 frame length", last_len, lens[k]);
                errs = 0;
                for (int i = 0; i < lens[k]; i++)
                    if (cap[i] !== pat(k * 13, i)) errs++;
                check("R3 frame bytes", errs, 0);
                rd(6'h10, v); check("R3 length cleared", v, 0);
                rd(6'h14, v); check("R4 tx done set", v, 32'h1);
                check("R10 irq with tx done", {31'b0, irq}, 1);
                wr(6'h14, 32'h1);
                check("R10 irq after ack", {31'b0, irq}, 0);
            end
            bp_en = 1'b0;
        end

        // R3 write during SEND is ignored
        begin
            int old, errs;
            old = frames;
            wr(6'h10, 16);
            for (int i = 0; i < 16; i++) wr(6'h20, {24'h0, pat(77, i)});
            wr(6'h20, 32'h77);
            rd(6'h10, v); check("R3 length zero during send", v, 0);
            wait_frame(old);
            errs = 0;
            for (int i = 0; i < 16; i++) if (cap[i] !== pat(77, i)) errs++;
            check("R3 send-time write ignored", errs, 0);
            check("R3 send-time len", last_len, 16);
            old = frames;
            wr(6'h10, 1); wr(6'h20, 32'h5C);
            wait_frame(old);
            check("R3 next frame clean", {24'h0, cap[0]}, 32'h5C);
            wr(6'h14, 32'h1);
        end

        // R5 R7 receive sweep
        for (int len = 1; len <= 12; len++) begin
            send_rx(len, len * 3);
            rd(6'h0C, v); check("R5 rx count", v, len);
            rd(6'h14, v); check("R5 rx done", v, 32'h2);
            for (int i = 0; i < len; i++) begin
                rd(6'h1C, v); check("R7 rx byte", v, {24'h0, pat(len * 3, i)});
                rd(6'h0C, v); check("R7 rx count dec", v, len - 1 - i);
            end
            rd(6'h1C, v); check("R7 empty read", v, 0);
            rd(6'h0C, v); check("R7 empty count", v, 0);
            wr(6'h14, 32'h2);
            rd(6'h14, v); check("R8 rx ack", v, 0);
        end

        // R5 stray beat without start
        @(negedge clk); rx_valid = 1'b1; rx_sop = 1'b0; rx_eop = 1'b1; rx_data = 8'hEE;
        @(negedge clk); rx_valid = 1'b0; rx_eop = 1'b0;
        rd(6'h0C, v); check("R5 stray beat count", v, 0);
        rd(6'h14, v); check("R5 stray beat no flag", v, 0);

        // R5 R6 oversize frame capped, full buffer refuses
        begin
            int errs;
            send_rx(FMAX + 6, 40);
            rd(6'h0C, v); check("R5 capped length", v, FMAX);
            @(negedge clk); #1;
            check("R6 refuse when full", {31'b0, rx_ready}, 0);
            rd(6'h1C, v); check("R7 first byte", v, {24'h0, pat(40, 0)});
            @(negedge clk); #1;
            check("R6 accept after one read", {31'b0, rx_ready}, 1);
            errs = 0;
            for (int i = 1; i < FMAX; i++) begin
                rd(6'h1C, v);
                if (v !== {24'h0, pat(40, i)}) errs++;
            end
            check("R5 capped bytes", errs, 0);
            rd(6'h0C, v); check("R7 drained", v, 0);
            wr(6'h14, 32'h2);
        end

        // R9 R10 test flag
        wr(6'h14, 32'h8000_0000);
        rd(6'h08, v); check("R10 busy after test", v, 1);
        check("R10 irq with test", {31'b0, irq}, 1);
        rd(6'h14, v); check("R9 read value", v, 32'h8000_0000);
        rd(6'h14, v); check("R9 cleared on read", v, 0);
        check("R10 irq after read clear", {31'b0, irq}, 0);
        rd(6'h08, v); check("R10 busy holds without write", v, 1);
        wr(6'h14, 32'h0);
        rd(6'h08, v); check("R10 busy after empty write", v, 0);

        // R8 priority sweep over bits 31, 1, 0 from all-set state
        for (int p = 0; p < 8; p++) begin
            logic t, r, x;
            send_tx(1, p);
            send_rx(1, p);
            wr(6'h14, 32'h8000_0000);
            wr(6'h14, {p[2], 29'b0, p[1], p[0]});
            x = 1'b1; r = 1'b1; t = 1'b1;
            if (p[0])      x = 1'b0;
            else if (p[1]) r = 1'b0;
            rd(6'h08, v); check("R10 busy after priority write", v, {31'b0, x | r | t});
            check("R10 irq after priority write", {31'b0, irq}, {31'b0, x | r | t});
            rd(6'h14, v); check("R8 priority result", v, {t, 29'b0, r, x});
            wr(6'h14, 32'h1); wr(6'h14, 32'h2);
            rd(6'h1C, v);
        end

        summary();
    end

endmodule